// File: doc/BRIEF.md
# Paged Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address. It uses a page table of 16 entries held in flip-flops. The upper four bits of the virtual address select a page. The lower twelve bits are the byte offset within a 4K page and pass to the output unchanged. Each table entry holds a residence flag, a 3-bit frame number and a dirty flag. A lookup that lands on a resident page returns the frame number joined to the offset. A lookup that lands on a non-resident page raises a fault instead.

The translation is registered, so each accepted request produces one response on the following cycle. A separate table write port loads an entry with a frame number and a residence value. Fault-handling software uses it to install a page after fetching it, and then reissues the faulting access. The same port clears residence when a page is evicted.

Each entry also keeps a dirty flag. The flag is set by write accesses that hit the page and is cleared whenever the entry is rewritten. Eviction logic therefore knows which pages must be copied back to storage.

Top module: `page_xlate`

## Requirements
- R1: After reset, every entry is non-resident and clean, so the first access to any page faults.
- R2: On a resident hit, rsp_paddr[11:0] equals the request's vaddr[11:0].
- R3: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and all response outputs come from registers.
- R4: On a resident hit, rsp_paddr[14:12] is the frame number of the entry selected by vaddr[15:12], and rsp_fault is 0.
- R5: A request to a non-resident page gives rsp_fault=1, rsp_paddr=0 and rsp_dirty=0, and it does not set that page's dirty flag.
- R6: A table write with tbl_we=1 stores tbl_frame and tbl_resident into entry tbl_idx. Writing tbl_resident=0 makes later accesses to that page fault.
- R7: When a table write and a lookup address the same entry in one cycle, the lookup returns the entry as it was before the write.
- R8: A hit with req_write=1 sets the page's dirty flag, and a hit with req_write=0 leaves it unchanged. rsp_dirty reports the flag as held before the access, and only on a hit.
- R9: A table write clears the dirty flag of its entry. This takes priority over a write access to the same entry in the same cycle.
- R10: While rsp_valid is 0, rsp_fault, rsp_dirty and rsp_paddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address: page number in bits 15:12, offset in bits 11:0 |
| req_write | input | 1 | The request is a store access |
| tbl_we | input | 1 | Page table write enable |
| tbl_idx | input | 4 | Page table entry to write |
| tbl_frame | input | 3 | Frame number to store |
| tbl_resident | input | 1 | Residence value to store |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_paddr | output | 15 | Physical address: frame in bits 14:12, offset in bits 11:0 |
| rsp_fault | output | 1 | The requested page was not resident |
| rsp_dirty | output | 1 | Dirty flag of the page before this access (hits only) |

## Verification
The hardest cases to reach are the ones where the table write port and the lookup address the same entry in the same cycle. In that cycle the lookup must see the old entry, and the dirty update must lose to the rewrite. The stimulus reaches these cases in two steps. It first sets up a resident page that is already dirty. It then issues a store to that page in the same cycle as a remap of it. Follow-up reads confirm the new frame and a clear dirty flag. A further case evicts a page that was resident, which checks that residence is cleared as well as set.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int PAGE_BITS   = 4,
  parameter int FRAME_BITS  = 3,
  parameter int OFFSET_BITS = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [PAGE_BITS+OFFSET_BITS-1:0]  req_vaddr,
  input  logic                              req_write,
  input  logic                              tbl_we,
  input  logic [PAGE_BITS-1:0]              tbl_idx,
  input  logic [FRAME_BITS-1:0]             tbl_frame,
  input  logic                              tbl_resident,
  output logic                              rsp_valid,
  output logic [FRAME_BITS+OFFSET_BITS-1:0] rsp_paddr,
  output logic                              rsp_fault,
  output logic                              rsp_dirty
);
  localparam int VA_W  = PAGE_BITS + OFFSET_BITS;
  localparam int PA_W  = FRAME_BITS + OFFSET_BITS;
  localparam int PAGES = 1 << PAGE_BITS;

  logic [FRAME_BITS-1:0] frame_q [PAGES];
  logic [PAGES-1:0]      res_q;
  logic [PAGES-1:0]      dirty_q;

  logic [PAGE_BITS-1:0]   page;
  logic [OFFSET_BITS-1:0] offset;
  logic                   hit;

  assign page   = req_vaddr[VA_W-1:OFFSET_BITS];
  assign offset = req_vaddr[OFFSET_BITS-1:0];
  assign hit    = req_valid && res_q[page];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      dirty_q <= '0;
      for (int i = 0; i < PAGES; i++) frame_q[i] <= '0;
    end else begin
      for (int i = 0; i < PAGES; i++) begin
        if (tbl_we && tbl_idx == PAGE_BITS'(i)) begin
          frame_q[i] <= tbl_frame;
          res_q[i]   <= tbl_resident;
          dirty_q[i] <= 1'b0;
        end else if (hit && req_write && page == PAGE_BITS'(i)) begin
          dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && !res_q[page];
      rsp_dirty <= hit && dirty_q[page];
      rsp_paddr <= hit ? {frame_q[page], offset} : PA_W'(0);
    end
  end
endmodule

module page_xlate_chk #(
  parameter int PAGE_BITS   = 4,
  parameter int FRAME_BITS  = 3,
  parameter int OFFSET_BITS = 12
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_valid,
  input logic [PAGE_BITS+OFFSET_BITS-1:0]  req_vaddr,
  input logic                              rsp_valid,
  input logic [FRAME_BITS+OFFSET_BITS-1:0] rsp_paddr,
  input logic                              rsp_fault,
  input logic                              rsp_dirty
);
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault || rsp_paddr[OFFSET_BITS-1:0] == $past(req_vaddr[OFFSET_BITS-1:0])));
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_dirty));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_fault && !rsp_dirty && rsp_paddr == '0));
endmodule

bind page_xlate page_xlate_chk #(
  .PAGE_BITS(PAGE_BITS), .FRAME_BITS(FRAME_BITS), .OFFSET_BITS(OFFSET_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .rsp_dirty(rsp_dirty)
);

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_vaddr = '0;
  logic        tbl_we = 0, tbl_resident = 0;
  logic [3:0]  tbl_idx = '0;
  logic [2:0]  tbl_frame = '0;
  logic        rsp_valid, rsp_fault, rsp_dirty;
  logic [14:0] rsp_paddr;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic        fault;
    logic        dirty;
    logic [14:0] pa;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [2:0] m_fr [16];
  logic [15:0] m_res = '0, m_dirty = '0;

  always #4 clk = ~clk;

  page_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_frame(tbl_frame), .tbl_resident(tbl_resident), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty)
  );

  task automatic step(input logic v, input logic [15:0] va, input logic wr,
                      input logic twe, input logic [3:0] ti, input logic [2:0] tf,
                      input logic tr, input string tag);
    exp_t e;
    logic [3:0] p;
    @(negedge clk);
    req_valid = v; req_vaddr = va; req_write = wr;
    tbl_we = twe; tbl_idx = ti; tbl_frame = tf; tbl_resident = tr;
    p = va[15:12];
    if (v) begin
      e.fault = !m_res[p];
      e.dirty = m_res[p] && m_dirty[p];
      e.pa    = m_res[p] ? {m_fr[p], va[11:0]} : 15'd0;
      e.tag   = tag;
      sb.push_back(e);
      if (wr && m_res[p] && !(twe && ti == p)) m_dirty[p] = 1'b1;
    end
    if (twe) begin
      m_fr[ti] = tf; m_res[ti] = tr; m_dirty[ti] = 1'b0;
    end
  endtask

  task automatic rd(input logic [15:0] va, input string tag);
    step(1, va, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [15:0] va, input string tag);
    step(1, va, 1, 0, 0, 0, 0, tag);
  endtask
  task automatic map(input logic [3:0] ti, input logic [2:0] tf, input logic tr);
    step(0, 0, 0, 1, ti, tf, tr, "");
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R3: response with no request, actual valid=1 expected valid=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_fault !== e.fault || rsp_dirty !== e.dirty || rsp_paddr !== e.pa) begin
            errors++;
            $display("FAIL %s: actual fault=%0b dirty=%0b pa=%h expected fault=%0b dirty=%0b pa=%h",
                     e.tag, rsp_fault, rsp_dirty, rsp_paddr, e.fault, e.dirty, e.pa);
          end
        end
      end else begin
        checks++;
        if (rsp_fault !== 1'b0 || rsp_dirty !== 1'b0 || rsp_paddr !== 15'd0) begin
          errors++;
          $display("FAIL R10: idle outputs actual fault=%0b dirty=%0b pa=%h expected 0 0 0000",
                   rsp_fault, rsp_dirty, rsp_paddr);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_fr[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_paddr !== 0 || rsp_dirty !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs actual v=%0b f=%0b pa=%h d=%0b expected all 0",
               rsp_valid, rsp_fault, rsp_paddr, rsp_dirty);
    end
    rst_n = 1;
    for (int i = 0; i < 16; i++) rd({i[3:0], 12'h5A5}, "R1");
    idle();
    map(4'd2, 3'd5, 1);
    map(4'd9, 3'd0, 1);
    map(4'd15, 3'd7, 1);
    rd(16'h2000, "R4");
    rd(16'h2FFF, "R2");
    rd(16'h9123, "R4");
    rd(16'hFABC, "R2");
    wr(16'h3010, "R5");
    map(4'd3, 3'd1, 1);
    rd(16'h3010, "R5");
    wr(16'h2004, "R8");
    rd(16'h2008, "R8");
    rd(16'h9000, "R8");
    rd(16'h9001, "R8");
    step(1, 16'h9777, 0, 1, 4'd9, 3'd3, 1, "R7");
    rd(16'h9777, "R6");
    map(4'd15, 3'd7, 0);
    rd(16'hF000, "R6");
    step(1, 16'h2ABC, 1, 1, 4'd2, 3'd6, 1, "R9");
    rd(16'h2ABC, "R9");
    wr(16'h2001, "R8");
    idle();
    rd(16'h2002, "R8");
    repeat (3) idle();
    while (sb.size() != 0) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R3: actual %0d pending expected 0", sb.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule